// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns three independent trouble indications into one clean system reset. A supply-undervoltage flag, an active-low push-button (manual) reset line and a one-cycle watchdog expiry request each force reset on as soon as they are seen. Reset stays on while any of them is still active. After the last one clears, reset is held for a full recovery interval. Any new trigger during that interval throws the partial count away, and the interval starts again only once every source is quiet.

The undervoltage flag and the manual reset line are asynchronous. Each passes through a two-flop synchronizer. The synchronized manual line then goes through a glitch filter that accepts a low level only after it has been seen for `FILT_LEN` consecutive clocks. The watchdog request is already synchronous and enters the sequencer directly. The recovery interval is `REC_TICKS` ticks of a prescaler enable input, so a slow tick gives real-time intervals and a fast tick gives short simulation runs. The reset is driven both active-low and active-high, and the two pins are always exact complements.

The sequencer has three states:
- `SUP_HOLD`: a source is active, or the block has just left its own reset.
- `SUP_RECOVER`: counting ticks.
- `SUP_RUN`: reset released.

The transitions are named as follows:
- HOLD→RECOVER ("quiet"): no source is active. The count is cleared.
- RECOVER→HOLD ("retrigger"): any source is active.
- RECOVER→RUN ("expire"): a tick arrives while the count is `REC_TICKS-1`.
- RUN→HOLD ("trip"): any source is active.

A synchronous active-low `rst_n` puts the sequencer in HOLD with the count at zero.

Top module: `sup_reset_gen`

## Requirements
- R1: A high on `uv_flag` makes `sys_rst_n` low at the third rising clock edge after it is applied, and reset stays on while the flag is high.
- R2: After `uv_flag` falls, with `tick_en` high every cycle, `sys_rst_n` stays low through edge `REC_TICKS+2` and goes high at edge `REC_TICKS+3`.
- R3: While `mr_n` is held low (longer than the filter), reset is on. A held-low `mr_n` turns reset on at edge `FILT_LEN+3`. After `mr_n` returns high, reset is released at edge `REC_TICKS+4`.
- R4: A low pulse on `mr_n` shorter than `FILT_LEN` clock cycles has no effect on either reset output.
- R5: A one-cycle high on `wd_expire` makes `sys_rst_n` low at the next edge. The output is released at edge `REC_TICKS+2` counted from the edge that sampled the request.
- R6: Any trigger seen during the recovery interval returns the block to HOLD. The full interval then restarts after the trigger clears.
- R7: The recovery count advances only on cycles with `tick_en` high. With no ticks, reset stays on indefinitely.
- R8: `sys_rst` is at all times the logical complement of `sys_rst_n`.
- R9: While `rst_n` is low, reset is on and the count is zero. With all sources quiet, reset is released at the `REC_TICKS+1`-th edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| tick_en | input | 1 | Prescaler enable, one recovery tick per high cycle |
| uv_flag | input | 1 | Asynchronous supply-undervoltage flag, active high |
| mr_n | input | 1 | Asynchronous manual reset request, active low |
| wd_expire | input | 1 | Synchronous watchdog expiry request, active high |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
The outputs are decoded straight from the sequencer state. A wrong state therefore shows on both pins in the same cycle: a spurious release shows as an early high on `sys_rst_n`, and a stuck state shows as a reset that never ends. A count error moves the release edge by whole cycles, so every release is checked at the exact edge before and the exact edge of release. A filter or synchronizer fault shifts the assertion edge of the manual or undervoltage path, or lets a short manual pulse through. Such a fault appears within `REC_TICKS` cycles as a low where the bench expects a high.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        SUP_HOLD    = 2'd0,
        SUP_RECOVER = 2'd1,
        SUP_RUN     = 2'd2
    } sup_state_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // One independent flop chain per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{IDLE_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int FILT_LEN = 4,
    localparam int FC_W    = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_sync_n,
    output logic mr_filt_n
);

    localparam logic [FC_W-1:0] LOW_LAST = FC_W'(FILT_LEN - 1);

    logic [FC_W-1:0] low_cnt;

    // A low is believed only after FILT_LEN consecutive low samples;
    // a high sample is believed at once and rearms the run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            mr_filt_n <= 1'b1;
        end else if (mr_sync_n) begin
            low_cnt   <= '0;
            mr_filt_n <= 1'b1;
        end else if (low_cnt == LOW_LAST) begin
            mr_filt_n <= 1'b0;
        end else begin
            low_cnt   <= low_cnt + 1'b1;
        end
    end

    // R4: the filtered line only falls after a full run of low samples
    p_full_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mr_filt_n) |-> ($past(low_cnt) == LOW_LAST && !$past(mr_sync_n)));

    // R3: a high sample always restores the filtered line next cycle
    p_high_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mr_sync_n |=> mr_filt_n);

endmodule

// File: rtl/sup_seq.sv
module sup_seq
    import sup_pkg::*;
#(
    parameter int REC_TICKS = 200,
    localparam int CNT_W    = (REC_TICKS > 2) ? $clog2(REC_TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic uv_s,
    input  logic mr_filt_n,
    input  logic wd_req,
    output logic rst_active
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_TICKS - 1);

    sup_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            any_src;

    assign any_src = uv_s | ~mr_filt_n | wd_req;

    // State and count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUP_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SUP_HOLD: begin
                cnt_d = '0;
                if (!any_src) begin
                    state_d = SUP_RECOVER;          // quiet
                end
            end
            SUP_RECOVER: begin
                if (any_src) begin
                    state_d = SUP_HOLD;             // retrigger
                    cnt_d   = '0;
                end else if (tick_en) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = SUP_RUN;          // expire
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SUP_RUN: begin
                cnt_d = '0;
                if (any_src) begin
                    state_d = SUP_HOLD;             // trip
                end
            end
            default: begin
                state_d = SUP_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        rst_active = (state_q != SUP_RUN);
    end

    // R6: any source during recovery returns to HOLD
    p_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RECOVER && any_src) |=> (state_q == SUP_HOLD && cnt_q == '0));

    // R7: count frozen on cycles without a tick
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RECOVER && !any_src && !tick_en) |=> (state_q == SUP_RECOVER && $stable(cnt_q)));

    // R2: release only after a full count of ticks
    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RUN && $past(state_q) != SUP_RUN) |->
            ($past(state_q) == SUP_RECOVER && $past(cnt_q) == CNT_LAST && $past(tick_en)));

    // R1: an undervoltage sample forces HOLD next cycle
    p_uv_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> state_q == SUP_HOLD);

    // R2: count never exceeds its last value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int REC_TICKS = 200,
    parameter int FILT_LEN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic uv_flag,
    input  logic mr_n,
    input  logic wd_expire,
    output logic sys_rst_n,
    output logic sys_rst
);

    logic [1:0] raw_async;
    logic [1:0] synced;
    logic       mr_filt_n;
    logic       rst_active;

    // bit 1 = undervoltage (idle 0), bit 0 = manual reset (idle 1)
    assign raw_async = {uv_flag, mr_n};

    sup_sync #(
        .WIDTH    (2),
        .STAGES   (2),
        .IDLE_VAL (2'b01)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_async),
        .sync_out (synced)
    );

    sup_mr_filter #(
        .FILT_LEN (FILT_LEN)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_sync_n (synced[0]),
        .mr_filt_n (mr_filt_n)
    );

    sup_seq #(
        .REC_TICKS (REC_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .uv_s       (synced[1]),
        .mr_filt_n  (mr_filt_n),
        .wd_req     (wd_expire),
        .rst_active (rst_active)
    );

    assign sys_rst_n = ~rst_active;
    assign sys_rst   = rst_active;

    // R5: a watchdog request shows as reset on the next edge
    p_wd_next_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !sys_rst_n);

    // R9: the cycle after a block reset, the output is still asserted
    p_after_init_r9: assert property (@(posedge clk)
        !rst_n |=> sys_rst);

endmodule

// File: tb/sup_reset_gen_bench.sv
module sup_reset_gen_bench;

    localparam int REC  = 8;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n, tick_en, uv_flag, mr_n, wd_expire;
    logic sys_rst_n, sys_rst;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    sup_reset_gen #(.REC_TICKS(REC), .FILT_LEN(FILT)) u_sup_reset_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .uv_flag(uv_flag),
        .mr_n(mr_n), .wd_expire(wd_expire), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
    );

    // Row: [15] uv [14] mr_n [13] wd [12] expected sys_rst_n [7:0] edges to wait
    localparam int NROW = 15;
    localparam logic [15:0] TBL [NROW] = '{
        {1'b1,1'b1,1'b0,1'b1,4'h0,8'd2},          // R1 not yet
        {1'b1,1'b1,1'b0,1'b0,4'h0,8'd1},          // R1 asserted at edge 3
        {1'b1,1'b1,1'b0,1'b0,4'h0,8'd5},          // R1 held
        {1'b0,1'b1,1'b0,1'b0,4'h0,8'(REC+2)},     // R2 still on
        {1'b0,1'b1,1'b0,1'b1,4'h0,8'd1},          // R2 released
        {1'b0,1'b1,1'b1,1'b0,4'h0,8'd1},          // R5 next edge
        {1'b0,1'b1,1'b0,1'b0,4'h0,8'(REC)},       // R5 still on
        {1'b0,1'b1,1'b0,1'b1,4'h0,8'd1},          // R5 released
        {1'b0,1'b0,1'b0,1'b1,4'h0,8'(FILT-1)},    // R4 short pulse
        {1'b0,1'b1,1'b0,1'b1,4'h0,8'(REC)},       // R4 ignored
        {1'b0,1'b0,1'b0,1'b1,4'h0,8'(FILT+2)},    // R3 not yet
        {1'b0,1'b0,1'b0,1'b0,4'h0,8'd1},          // R3 asserted
        {1'b0,1'b0,1'b0,1'b0,4'h0,8'd20},         // R3 held
        {1'b0,1'b1,1'b0,1'b0,4'h0,8'(REC+3)},     // R3 still on
        {1'b0,1'b1,1'b0,1'b1,4'h0,8'd1}           // R3 released
    };

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_n);
        total++;
        if (sys_rst_n !== exp_n) begin
            bad++;
            $display("FAIL %s: sys_rst_n=%b expected %b at %0t", req, sys_rst_n, exp_n, $time);
        end
        total++;
        if (sys_rst !== ~exp_n) begin   // R8 complement
            bad++;
            $display("FAIL R8: sys_rst=%b expected %b at %0t", sys_rst, ~exp_n, $time);
        end
    endtask

    task automatic wd_pulse();
        wd_expire = 1'b1;
        wait_edges(1);
        wd_expire = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog: run hung, expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; tick_en = 1'b1; uv_flag = 1'b0; mr_n = 1'b1; wd_expire = 1'b0;
        wait_edges(5);
        check("R9", 1'b0);
        rst_n = 1'b1;
        wait_edges(REC);
        check("R9", 1'b0);
        wait_edges(1);
        check("R9", 1'b1);

        for (int i = 0; i < NROW; i++) begin
            uv_flag   = TBL[i][15];
            mr_n      = TBL[i][14];
            wd_expire = TBL[i][13];
            wait_edges(int'(TBL[i][7:0]));
            check($sformatf("table row %0d", i), TBL[i][12]);
        end
        wd_expire = 1'b0;

        // R6: second watchdog request mid-recovery restarts the interval
        wd_pulse();
        wait_edges(5);
        check("R6", 1'b0);
        wd_pulse();
        wait_edges(REC);
        check("R6", 1'b0);
        wait_edges(1);
        check("R6", 1'b1);

        // R6: undervoltage during recovery, full interval after it clears
        wd_pulse();
        wait_edges(4);
        uv_flag = 1'b1;
        wait_edges(4);
        uv_flag = 1'b0;
        wait_edges(REC + 2);
        check("R6", 1'b0);
        wait_edges(1);
        check("R6", 1'b1);

        // R7: no ticks, no progress
        tick_en = 1'b0;
        wd_pulse();
        wait_edges(40);
        check("R7", 1'b0);
        tick_en = 1'b1;
        wait_edges(REC - 1);
        check("R7", 1'b0);
        wait_edges(1);
        check("R7", 1'b1);

        // R7: tick every other cycle doubles the interval
        wd_pulse();
        wait_edges(1);               // now in recovery, count zero
        for (int k = 0; k < 2 * REC - 1; k++) begin
            tick_en = k[0];
            wait_edges(1);
        end
        tick_en = 1'b0;
        check("R7", 1'b0);
        tick_en = 1'b1;
        wait_edges(1);
        check("R7", 1'b1);

        // R9: block reset mid-run reasserts at once
        rst_n = 1'b0;
        wait_edges(1);
        check("R9", 1'b0);
        rst_n = 1'b1;
        wait_edges(REC + 1);
        check("R9", 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule